// File: doc/BRIEF.md
# Selector-Indexed Blob Read Port

This block is a small bus slave that exposes a fixed set of read-only byte arrays ("blobs") through two registers. Software writes a 16-bit key to a write-only selector register. It then drains the chosen blob through a read-only data register. A hidden byte cursor starts at zero on every selector write and moves forward with each data read. Bytes beyond the end of a blob read back as zero, so the cursor never wraps and no error is raised.

Two personalities are chosen by a parameter. In narrow mode the selector sits at address 0 and takes its key little-endian. The data register sits at address 1 and returns one byte per read. In wide mode the data register sits at address 0 and returns 1, 2, 4 or 8 bytes per read. The selector sits at address 8 and takes its key big-endian. The blob set is computed from parameters: a four-byte identity string at key 0, a 32-bit revision at key 1, and a run of generated blobs starting at a configurable first key, with lengths that grow linearly.

Top module: `blob_read_port`

## Requirements
- R1: After reset the selected key is 0, the cursor is 0, `bus_rdata` is 0 and `bus_rvalid` is 0. A data read issued with no prior selector write returns the identity blob from its first byte.
- R2: A write at the selector address (narrow 0, wide 8) loads the key from `bus_wdata`. In narrow mode `bus_wdata[7:0]` is the low key byte. In wide mode `bus_wdata[7:0]` is the high key byte.
- R3: Every selector write resets the cursor to 0, including a write of the key that is already selected.
- R4: A read at the data address (narrow 1, wide 0) sets `bus_rdata` on the next clock edge and pulses `bus_rvalid` high for that one cycle. Byte lane k (`bus_rdata[8k+7:8k]`) carries the blob byte at cursor+k, and lanes at or above the access width are 0.
- R5: Each data read advances the cursor by the access width in bytes.
- R6: Blob bytes at offsets at or above the blob length read as 0x00, including the tail lanes of a read that straddles the end. The cursor stops at the blob length.
- R7: Key 0 is a 4-byte blob holding `SIG_WORD` with bits [31:24] at offset 0. Key 1 is a 4-byte blob holding `REV_WORD` little-endian, with bits [7:0] at offset 0.
- R8: Key FIRST_KEY+j, for j < NUM_GEN, has length LEN_BASE+j*LEN_STEP. Its byte at offset o is (SEED + 32*j + 3*o) mod 256.
- R9: Any other key has length 0, so every read of it returns all zeros.
- R10: `bus_size` gives the access width as log2 of the byte count (0..3 for 1, 2, 4, 8 bytes). In narrow mode every read is one byte wide, whatever `bus_size` holds.
- R11: A write at the data address and a read at any address other than the data address leave the key and the cursor unchanged, and such a read gives no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | log2 of read width in bytes |
| bus_wdata | input | 16 | Key written to the selector |
| bus_rdata | output | 64 (wide) / 8 (narrow) | Read data, lane 0 = lowest blob offset |
| bus_rvalid | output | 1 | High the cycle after a data read |

## Verification
The bench builds two instances side by side: one wide, one narrow. Both use four generated blobs of lengths 3, 8, 13 and 18 starting at key 0x0020. With lengths this short, every key of interest can be drained past its end at each access width, and with a cycling mix of widths, within a few thousand cycles. Every straddle position and every saturation point is therefore reached. The key list includes byte-swapped twins (0x0100 against 0x0001, 0x2000 against 0x0020), so a selector taken with the wrong endianness lands on a different blob and shows up in the data.

// File: rtl/blob_pkg.sv
package blob_pkg;

   localparam logic [15:0] IDENT_KEY = 16'h0000;
   localparam logic [15:0] REVN_KEY  = 16'h0001;

   // Length of the blob behind a key; unknown keys are empty.
   function automatic int unsigned blob_len(input logic [15:0] key,
                                            input int unsigned first_key,
                                            input int unsigned num_gen,
                                            input int unsigned len_base,
                                            input int unsigned len_step);
      int unsigned k;
      k = {16'b0, key};
      if (key == IDENT_KEY || key == REVN_KEY) return 4;
      if (k >= first_key && k < first_key + num_gen)
         return len_base + (k - first_key) * len_step;
      return 0;
   endfunction

   // Byte of a blob at a given offset; zero beyond the end.
   function automatic logic [7:0] blob_byte(input logic [15:0] key,
                                            input int unsigned off,
                                            input logic [31:0] sig,
                                            input logic [31:0] rev,
                                            input int unsigned first_key,
                                            input int unsigned num_gen,
                                            input int unsigned len_base,
                                            input int unsigned len_step,
                                            input logic [7:0] seed);
      int unsigned len;
      int unsigned idx;
      logic [7:0]  b;
      b   = 8'h00;
      len = blob_len(key, first_key, num_gen, len_base, len_step);
      if (off < len) begin
         if (key == IDENT_KEY)      b = sig[8*(3-off) +: 8];
         else if (key == REVN_KEY)  b = rev[8*off +: 8];
         else begin
            idx = {16'b0, key} - first_key;
            b   = seed + 8'(idx * 32) + 8'(off * 3);
         end
      end
      return b;
   endfunction

endpackage

// File: rtl/blob_key_unpack.sv
module blob_key_unpack #(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [15:0] raw,
   output logic [15:0] key
);
   generate
      if (BIG_ENDIAN) begin : g_be
         assign key = {raw[7:0], raw[15:8]};
      end else begin : g_le
         assign key = raw;
      end
   endgenerate
endmodule

// File: rtl/blob_rom.sv
module blob_rom
   import blob_pkg::*;
#(
   parameter logic [31:0] SIG_WORD  = 32'h424C_4F42,
   parameter logic [31:0] REV_WORD  = 32'h0000_0003,
   parameter int unsigned FIRST_KEY = 32,
   parameter int unsigned NUM_GEN   = 4,
   parameter int unsigned LEN_BASE  = 3,
   parameter int unsigned LEN_STEP  = 5,
   parameter logic [7:0]  SEED      = 8'h40,
   parameter int unsigned OFF_W     = 9
) (
   input  logic [15:0]      key,
   input  logic [OFF_W-1:0] off,
   output logic [7:0]       byte_o
);
   always_comb begin
      byte_o = blob_byte(key, {{(32-OFF_W){1'b0}}, off}, SIG_WORD, REV_WORD,
                         FIRST_KEY, NUM_GEN, LEN_BASE, LEN_STEP, SEED);
   end
endmodule

// File: rtl/blob_read_port.sv
module blob_read_port
   import blob_pkg::*;
#(
   parameter bit          MMIO_MODE = 1'b1,
   parameter int unsigned ADDR_W    = 4,
   parameter logic [31:0] SIG_WORD  = 32'h424C_4F42,
   parameter logic [31:0] REV_WORD  = 32'h0000_0003,
   parameter int unsigned FIRST_KEY = 32,
   parameter int unsigned NUM_GEN   = 4,
   parameter int unsigned LEN_BASE  = 3,
   parameter int unsigned LEN_STEP  = 5,
   parameter logic [7:0]  SEED      = 8'h40
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_wr,
   input  logic                              bus_rd,
   input  logic [1:0]                        bus_size,
   input  logic [15:0]                       bus_wdata,
   output logic [(MMIO_MODE ? 64 : 8)-1:0]   bus_rdata,
   output logic                              bus_rvalid
);
   localparam int unsigned NBYTES    = MMIO_MODE ? 8 : 1;
   localparam int unsigned CTRL_ADDR = MMIO_MODE ? 8 : 0;
   localparam int unsigned DATA_ADDR = MMIO_MODE ? 0 : 1;
   localparam int unsigned GEN_MAX   = LEN_BASE + (NUM_GEN - 1) * LEN_STEP;
   localparam int unsigned MAX_LEN   = (GEN_MAX > 4) ? GEN_MAX : 4;
   localparam int unsigned OFF_W     = $clog2(MAX_LEN + 1);
   localparam int unsigned LOFF_W    = OFF_W + 4;

   generate
      if (ADDR_W < 4)
         $error("blob_read_port: ADDR_W must reach address 8");
      if (NUM_GEN < 1)
         $error("blob_read_port: NUM_GEN must be at least 1");
      if (FIRST_KEY < 2 || FIRST_KEY + NUM_GEN > 65536)
         $error("blob_read_port: generated keys must lie in 2..65535");
   endgenerate

   logic [15:0]      sel_key;
   logic [OFF_W-1:0] offset;
   logic [OFF_W-1:0] cur_len;
   logic [15:0]      wr_key;
   logic             ctrl_hit;
   logic             data_hit;
   logic [3:0]       req_bytes;
   logic [3:0]       acc_bytes;
   logic [LOFF_W-1:0] sum_off;
   logic [OFF_W-1:0] nxt_off;
   logic [7:0]       lane_byte [NBYTES];

   assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign data_hit = bus_rd && (bus_addr == ADDR_W'(DATA_ADDR));

   blob_key_unpack #(.BIG_ENDIAN(MMIO_MODE)) u_unpack (
      .raw (bus_wdata),
      .key (wr_key)
   );

   always_comb begin
      cur_len = OFF_W'(blob_len(sel_key, FIRST_KEY, NUM_GEN, LEN_BASE, LEN_STEP));
   end

   // Access width, clamped to the data register width of the mode.
   always_comb begin
      req_bytes = 4'd1 << bus_size;
      acc_bytes = (req_bytes > 4'(NBYTES)) ? 4'(NBYTES) : req_bytes;
      sum_off   = {4'b0, offset} + LOFF_W'(acc_bytes);
      nxt_off   = (sum_off > {4'b0, cur_len}) ? cur_len : sum_off[OFF_W-1:0];
   end

   genvar gl;
   generate
      for (gl = 0; gl < NBYTES; gl++) begin : g_lane
         logic [LOFF_W-1:0] lane_off;
         assign lane_off = {4'b0, offset} + LOFF_W'(gl);
         blob_rom #(
            .SIG_WORD (SIG_WORD),  .REV_WORD (REV_WORD),
            .FIRST_KEY(FIRST_KEY), .NUM_GEN  (NUM_GEN),
            .LEN_BASE (LEN_BASE),  .LEN_STEP (LEN_STEP),
            .SEED     (SEED),      .OFF_W    (LOFF_W)
         ) u_rom (
            .key    (sel_key),
            .off    (lane_off),
            .byte_o (lane_byte[gl])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_key    <= 16'h0000;
         offset     <= '0;
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= data_hit;
         if (ctrl_hit) begin
            sel_key <= wr_key;
            offset  <= '0;
         end else if (data_hit) begin
            offset <= nxt_off;
            for (int i = 0; i < NBYTES; i++) begin
               bus_rdata[8*i +: 8] <= (4'(i) < acc_bytes) ? lane_byte[i] : 8'h00;
            end
         end
      end
   end
endmodule

// File: rtl/blob_read_port_chk.sv
module blob_read_port_chk #(
   parameter bit          MMIO_MODE = 1'b1,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned OFF_W     = 5
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [ADDR_W-1:0]                bus_addr,
   input logic                             bus_wr,
   input logic                             bus_rd,
   input logic [(MMIO_MODE ? 64 : 8)-1:0]  bus_rdata,
   input logic                             bus_rvalid,
   input logic [15:0]                      sel_key,
   input logic [OFF_W-1:0]                 offset,
   input logic [OFF_W-1:0]                 cur_len
);
   localparam int unsigned C_ADDR = MMIO_MODE ? 8 : 0;
   localparam int unsigned D_ADDR = MMIO_MODE ? 0 : 1;

   logic c_hit, d_hit;
   assign c_hit = bus_wr && (bus_addr == ADDR_W'(C_ADDR));
   assign d_hit = bus_rd && (bus_addr == ADDR_W'(D_ADDR));

   assert_cursor_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      offset <= cur_len);

   assert_select_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      c_hit |=> offset == '0);

   assert_read_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      d_hit |=> bus_rvalid);

   assert_no_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !d_hit |=> !bus_rvalid);

   assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_hit && !d_hit) |=> ($stable(offset) && $stable(sel_key)));

   assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_hit && offset == cur_len) |=> bus_rdata == '0);
endmodule

bind blob_read_port blob_read_port_chk #(
   .MMIO_MODE(MMIO_MODE), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .sel_key    (sel_key),
   .offset     (offset),
   .cur_len    (cur_len)
);

// File: tb/tb_blob_read_port.sv
`timescale 1ns/1ps
module tb_blob_read_port;
   localparam logic [31:0] SIG = 32'h424C_4F42;
   localparam logic [31:0] REV = 32'h0000_0003;
   localparam int FK = 32, NG = 4, LB = 3, LS = 5;
   localparam logic [7:0] SD = 8'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [3:0]  m_addr = '0;  logic m_wr = 0, m_rd = 0;
   logic [1:0]  m_size = '0;  logic [15:0] m_wdata = '0;
   logic [63:0] m_rdata;      logic m_rvalid;
   logic [3:0]  p_addr = '0;  logic p_wr = 0, p_rd = 0;
   logic [1:0]  p_size = '0;  logic [15:0] p_wdata = '0;
   logic [7:0]  p_rdata;      logic p_rvalid;

   int tests = 0, fails = 0;

   blob_read_port #(.MMIO_MODE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_wr(m_wr), .bus_rd(m_rd),
      .bus_size(m_size), .bus_wdata(m_wdata), .bus_rdata(m_rdata), .bus_rvalid(m_rvalid));

   blob_read_port #(.MMIO_MODE(1'b0)) dut_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(p_addr), .bus_wr(p_wr), .bus_rd(p_rd),
      .bus_size(p_size), .bus_wdata(p_wdata), .bus_rdata(p_rdata), .bus_rvalid(p_rvalid));

   // Reference blob model, written from the requirements (R7, R8, R9).
   function automatic int exp_len(input int key);
      if (key == 0 || key == 1) return 4;
      if (key >= FK && key < FK + NG) return LB + (key - FK) * LS;
      return 0;
   endfunction

   function automatic logic [7:0] exp_byte(input int key, input int off);
      if (off >= exp_len(key)) return 8'h00;
      if (key == 0) return SIG[8*(3-off) +: 8];
      if (key == 1) return REV[8*off +: 8];
      return 8'((int'(SD) + 32*(key - FK) + 3*off) % 256);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic m_sel(input int key);
      @(negedge clk);
      m_addr = 4'd8; m_wr = 1'b1; m_wdata = {8'(key), 8'(key >> 8)};
      @(negedge clk);
      m_wr = 1'b0;
   endtask

   task automatic p_sel(input int key);
      @(negedge clk);
      p_addr = 4'd0; p_wr = 1'b1; p_wdata = 16'(key);
      @(negedge clk);
      p_wr = 1'b0;
   endtask

   // Wide read at the data address; checks rdata against model, returns new cursor.
   task automatic m_read(input int key, input int s, inout int off, input string req);
      logic [63:0] e;
      int n;
      n = 1 << s;
      e = '0;
      for (int i = 0; i < n; i++) e[8*i +: 8] = exp_byte(key, off + i);
      @(negedge clk);
      m_addr = 4'd0; m_rd = 1'b1; m_size = 2'(s);
      @(negedge clk);
      m_rd = 1'b0;
      check(m_rdata == e, req, m_rdata, e);
      check(m_rvalid == 1'b1, "R4 rvalid", {63'b0, m_rvalid}, 64'd1);
      off = (off + n > exp_len(key)) ? exp_len(key) : off + n;
   endtask

   task automatic p_read(input int key, input int s, inout int off, input string req);
      logic [7:0] e;
      e = exp_byte(key, off);
      @(negedge clk);
      p_addr = 4'd1; p_rd = 1'b1; p_size = 2'(s);
      @(negedge clk);
      p_rd = 1'b0;
      check(p_rdata == e, req, {56'b0, p_rdata}, {56'b0, e});
      check(p_rvalid == 1'b1, "R4 rvalid narrow", {63'b0, p_rvalid}, 64'd1);
      off = (off + 1 > exp_len(key)) ? exp_len(key) : off + 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   int keys [10] = '{0, 1, 32, 33, 34, 35, 5, 256, 8192, 36};

   initial begin
      int off;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(m_rdata == '0 && !m_rvalid, "R1 reset wide", m_rdata, 64'd0);
      check(p_rdata == '0 && !p_rvalid, "R1 reset narrow", {56'b0, p_rdata}, 64'd0);
      off = 0; m_read(0, 2, off, "R1 R7 default key wide");
      off = 0; p_read(0, 0, off, "R1 R7 default key narrow");

      // R2 R5 R6 R7 R8 R9 R10: every key, every fixed width, drained past the end
      foreach (keys[k]) begin
         for (int s = 0; s < 4; s++) begin
            m_sel(keys[k]);
            off = 0;
            for (int r = 0; r < exp_len(keys[k]) / (1 << s) + 2; r++)
               m_read(keys[k], s, off, "R2 R5 R6 R8 R9 R10 wide sweep");
         end
         // cycling widths exercise straddles at every alignment
         m_sel(keys[k]);
         off = 0;
         for (int r = 0; r < 10; r++)
            m_read(keys[k], r % 4, off, "R4 R6 mixed widths");
         // narrow mode: bus_size must not widen the access
         p_sel(keys[k]);
         off = 0;
         for (int r = 0; r < exp_len(keys[k]) + 3; r++)
            p_read(keys[k], r % 4, off, "R2 R6 R10 narrow sweep");
      end

      // R3: reselecting the same key restarts at offset 0
      m_sel(34); off = 0;
      m_read(34, 1, off, "R3 pre"); m_read(34, 1, off, "R3 pre");
      m_sel(34); off = 0;
      m_read(34, 2, off, "R3 reselect wide");
      p_sel(35); off = 0;
      p_read(35, 0, off, "R3 pre narrow");
      p_sel(35); off = 0;
      p_read(35, 0, off, "R3 reselect narrow");

      // R11: writes to data address and reads elsewhere are ignored
      m_sel(33); off = 0;
      m_read(33, 0, off, "R11 setup");
      @(negedge clk); m_addr = 4'd0; m_wr = 1'b1; m_wdata = 16'h0100;
      @(negedge clk); m_wr = 1'b0; m_addr = 4'd8; m_rd = 1'b1; m_size = 2'd3;
      @(negedge clk); m_rd = 1'b0;
      check(!m_rvalid, "R11 no rvalid on selector read", {63'b0, m_rvalid}, 64'd0);
      m_read(33, 1, off, "R11 cursor and key kept");
      p_sel(34); off = 0;
      @(negedge clk); p_addr = 4'd1; p_wr = 1'b1; p_wdata = 16'h0001;
      @(negedge clk); p_wr = 1'b0; p_addr = 4'd3; p_rd = 1'b1;
      @(negedge clk); p_rd = 1'b0;
      check(!p_rvalid, "R11 no rvalid narrow", {63'b0, p_rvalid}, 64'd0);
      p_read(34, 0, off, "R11 narrow cursor kept");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule